// File: doc/BRIEF.md
# Attenuator Control-Source Selector with Power-Up Sequencing

This block chooses the 7-bit code that sets a step attenuator. The code can come from one of three places. The first is a word delivered by a serial front end, which has already done the shifting and the address compare and marks an accepted word with a one-cycle strobe. The second is a parallel bus captured through a latch enable. The third is the same parallel bus passed straight through while the latch enable is held high. A select input chooses serial (high) or parallel (low) operation, and it may change at any time while the block runs.

After reset the block applies a defined start-up state. If reset is released with parallel operation selected and the latch enable high, the block treats this as direct operation. It holds full attenuation for a delay counted in ticks of an external timebase and then adopts the parallel pins. In every other case it holds full attenuation until the first serial word is accepted or the latch enable first goes high.

The controller is a five-state machine:
- `ST_BOOT`: one cycle after reset, where the start-up path is chosen.
- `ST_DLY`: the direct-mode start-up delay.
- `ST_MAX`: full attenuation, waiting for a first load.
- `ST_SER`: serial operation.
- `ST_PAR`: parallel operation.

The transitions are:
- `ST_BOOT` goes to `ST_DLY` when the parallel select and LE are both present; otherwise it goes to `ST_MAX`.
- `ST_DLY` goes to `ST_PAR` on delay expiry.
- `ST_MAX` goes to `ST_SER` on an accepted serial word in serial mode, or to `ST_PAR` on LE high in parallel mode.
- `ST_SER` goes to `ST_PAR` when the select drops.
- `ST_PAR` goes to `ST_SER` when the select rises.

Top module: `atten_mode_ctrl`

## Requirements
- R1: `ps_serial` = 1 makes the serial word the only source of the code; `ps_serial` = 0 makes the parallel bus the only source.
- R2: The code is unsigned, 0.25 dB per LSB. Code 0 is minimum attenuation and code 127 (all ones) is the 31.75 dB full scale. Both extremes pass to `atten_code` unchanged.
- R3: In parallel operation with `le` low, changes on `par_code` leave `atten_code` unchanged.
- R4: In parallel operation with `le` high, `atten_code` equals the `par_code` value sampled at the previous clock edge. When `le` falls, the value captured at the last edge with `le` high is kept.
- R5: When reset is released in serial mode, or in parallel mode with `le` low, `atten_code` stays 127. It leaves 127 only on the first accepted serial word (serial mode) or the first cycle with `le` high (parallel mode).
- R6: When reset is released in parallel mode with `le` high, `atten_code` stays 127 for DELAY_US*TICKS_PER_US counted ticks, with all inputs other than `tick` ignored. It then takes `par_code`. Ticks are counted from the second clock edge after reset release.
- R7: A `ser_load` strobe in serial mode loads `ser_word` at that edge. A `ser_load` strobe in parallel mode has no effect.
- R8: On a change of `ps_serial`, `atten_code` keeps its last value until the new source loads (a `ser_load` strobe, or `le` high).
- R9: Asserting `rst_n` low sets `atten_code` to 127 at once and re-runs the start-up sequence on release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release restarts the start-up sequence |
| ps_serial | input | 1 | Source select: 1 serial, 0 parallel |
| le | input | 1 | Latch enable for the parallel bus (high = transparent) |
| par_code | input | 7 | Parallel attenuation bus |
| ser_word | input | 7 | Code word from the serial front end |
| ser_load | input | 1 | One-cycle strobe: `ser_word` is valid and addressed to this block |
| tick | input | 1 | Timebase pulse counted during the direct start-up delay |
| atten_code | output | 7 | Active attenuation code, 0.25 dB per LSB |

## Verification
Every load reaches `atten_code` one clock edge after the inputs that cause it are sampled. The bench therefore drives inputs just after a rising edge and reads the output just after the next rising edge, or several edges later when it checks that a value is held. The direct start-up result is due at the 401st edge after reset release: one edge for `ST_BOOT`, then 400 counted ticks with `tick` held high. The bench checks 127 right after edge 400 and the pin value right after edge 401. The reset value is checked a fraction of a cycle after `rst_n` falls, with no clock edge in between.

// File: rtl/atten_pkg.sv
package atten_pkg;

    localparam int CODE_W = 7;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_MAX = '1;

    typedef enum logic [2:0] {
        ST_BOOT = 3'd0,
        ST_DLY  = 3'd1,
        ST_MAX  = 3'd2,
        ST_SER  = 3'd3,
        ST_PAR  = 3'd4
    } mode_st_t;

endpackage

// File: rtl/atten_pwrup_timer.sv
module atten_pwrup_timer #(
    parameter int DELAY_TICKS = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CNT_W = $clog2(DELAY_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    assign done = run && tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || done) begin
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST) else $error("tick counter past limit"); // R6

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !clr |=> $stable(cnt)) else $error("counter moved while idle"); // R6

endmodule

// File: rtl/atten_mode_fsm.sv
module atten_mode_fsm
    import atten_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ps_serial,
    input  logic     le,
    input  logic     ser_load,
    input  logic     dly_done,
    output mode_st_t st
);
    mode_st_t st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_BOOT;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_BOOT: st_nxt = (!ps_serial && le) ? ST_DLY : ST_MAX;
            ST_DLY:  st_nxt = dly_done ? ST_PAR : ST_DLY;
            ST_MAX: begin
                if (ps_serial && ser_load) begin
                    st_nxt = ST_SER;
                end else if (!ps_serial && le) begin
                    st_nxt = ST_PAR;
                end
            end
            ST_SER:  st_nxt = ps_serial ? ST_SER : ST_PAR;
            ST_PAR:  st_nxt = ps_serial ? ST_SER : ST_PAR;
            default: st_nxt = ST_BOOT;
        endcase
    end

    AST_BOOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_BOOT |=> st != ST_BOOT) else $error("boot state repeated"); // R5

    AST_DLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_DLY && !dly_done |=> st == ST_DLY) else $error("left delay early"); // R6

endmodule

// File: rtl/atten_code_reg.sv
module atten_code_reg
    import atten_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  mode_st_t st,
    input  logic     ps_serial,
    input  logic     le,
    input  logic     ser_load,
    input  logic     dly_done,
    input  code_t    par_code,
    input  code_t    ser_word,
    output code_t    code
);
    code_t code_nxt;

    always_comb begin
        code_nxt = code;
        unique case (st)
            ST_BOOT: code_nxt = CODE_MAX;
            ST_DLY:  code_nxt = dly_done ? par_code : CODE_MAX;
            ST_MAX, ST_SER, ST_PAR: begin
                if (ps_serial) begin
                    if (ser_load) begin
                        code_nxt = ser_word;
                    end
                end else if (le) begin
                    code_nxt = par_code;
                end
            end
            default: code_nxt = CODE_MAX;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= CODE_MAX;
        end else begin
            code <= code_nxt;
        end
    end

endmodule

// File: rtl/atten_mode_ctrl.sv
module atten_mode_ctrl
    import atten_pkg::*;
#(
    parameter int DELAY_US     = 400,
    parameter int TICKS_PER_US = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ps_serial,
    input  logic                le,
    input  logic [CODE_W-1:0]   par_code,
    input  logic [CODE_W-1:0]   ser_word,
    input  logic                ser_load,
    input  logic                tick,
    output logic [CODE_W-1:0]   atten_code
);
    localparam int DELAY_TICKS = DELAY_US * TICKS_PER_US;

    mode_st_t st;
    logic     dly_done;

    atten_pwrup_timer #(
        .DELAY_TICKS (DELAY_TICKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st == ST_BOOT),
        .run   (st == ST_DLY),
        .tick  (tick),
        .done  (dly_done)
    );

    atten_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ps_serial (ps_serial),
        .le        (le),
        .ser_load  (ser_load),
        .dly_done  (dly_done),
        .st        (st)
    );

    atten_code_reg u_code (
        .clk       (clk),
        .rst_n     (rst_n),
        .st        (st),
        .ps_serial (ps_serial),
        .le        (le),
        .ser_load  (ser_load),
        .dly_done  (dly_done),
        .par_code  (par_code),
        .ser_word  (ser_word),
        .code      (atten_code)
    );

    AST_BOOT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_BOOT |-> atten_code == CODE_MAX) else $error("boot not at full scale"); // R9

    AST_DLY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_DLY |-> atten_code == CODE_MAX) else $error("delay not at full scale"); // R6

    AST_WAIT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_MAX |-> atten_code == CODE_MAX) else $error("waiting state not full scale"); // R5

    AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st != ST_BOOT && st != ST_DLY && !ps_serial && !le |=> $stable(atten_code))
        else $error("parallel code moved with le low"); // R3

    AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st != ST_BOOT && st != ST_DLY && !ps_serial && le |=> atten_code == $past(par_code))
        else $error("direct code not followed"); // R4

    AST_SER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        st != ST_BOOT && st != ST_DLY && ps_serial && ser_load |=> atten_code == $past(ser_word))
        else $error("serial word not loaded"); // R7

    AST_SER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        st != ST_BOOT && st != ST_DLY && ps_serial && !ser_load |=> $stable(atten_code))
        else $error("serial code moved without load"); // R1

    AST_SWITCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_SER && !ps_serial && !le |=> $stable(atten_code))
        else $error("code lost on switch to parallel"); // R8

endmodule

// File: tb/tb_atten_mode_ctrl.sv
module tb_atten_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ps_serial = 1'b0;
    logic       le = 1'b0;
    logic [6:0] par_code = '0;
    logic [6:0] ser_word = '0;
    logic       ser_load = 1'b0;
    logic       tick = 1'b1;
    logic [6:0] atten_code;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    atten_mode_ctrl #(.DELAY_US(400), .TICKS_PER_US(1)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ps_serial  (ps_serial),
        .le         (le),
        .par_code   (par_code),
        .ser_word   (ser_word),
        .ser_load   (ser_load),
        .tick       (tick),
        .atten_code (atten_code)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [6:0] exp);
        n_run++;
        if (atten_code !== exp) begin
            n_fail++;
            $display("FAIL %s: atten_code=%0d expected=%0d", req, atten_code, exp);
        end
    endtask

    task automatic power_up(input logic ser, input logic l, input logic [6:0] pins);
        rst_n = 1'b0;
        ps_serial = ser;
        le = l;
        par_code = pins;
        ser_load = 1'b0;
        step(3);
        chk("R9 in reset", 7'd127);
        rst_n = 1'b1;
    endtask

    task automatic t_pwrup_latched;
        power_up(1'b0, 1'b0, 7'd5);
        step(6);
        chk("R5 latched start", 7'd127);
        par_code = 7'd64;
        step(3);
        chk("R3 R5 pins ignored before latch", 7'd127);
        le = 1'b1;
        step(1);
        chk("R4 first latch", 7'd64);
        le = 1'b0;
        step(1);
        par_code = 7'd9;
        step(3);
        chk("R3 hold with le low", 7'd64);
    endtask

    task automatic t_direct_follow;
        le = 1'b1;
        par_code = 7'd0;
        step(1);
        chk("R2 code 0", 7'd0);
        par_code = 7'd127;
        step(1);
        chk("R2 code 127", 7'd127);
        par_code = 7'd42;
        step(1);
        chk("R4 follow", 7'd42);
        par_code = 7'd43;
        step(1);
        le = 1'b0;
        par_code = 7'd100;
        step(2);
        chk("R4 capture at le fall", 7'd43);
    endtask

    task automatic t_pwrup_serial;
        power_up(1'b1, 1'b0, 7'd0);
        step(6);
        chk("R5 serial start", 7'd127);
        ser_word = 7'd33;
        ser_load = 1'b1;
        step(1);
        ser_load = 1'b0;
        chk("R7 serial load", 7'd33);
        ser_word = 7'd50;
        le = 1'b1;
        par_code = 7'd11;
        step(3);
        chk("R1 parallel pins ignored in serial", 7'd33);
        le = 1'b0;
    endtask

    task automatic t_mode_switch;
        ps_serial = 1'b0;
        step(3);
        chk("R8 kept after switch to parallel", 7'd33);
        ser_word = 7'd99;
        ser_load = 1'b1;
        step(1);
        ser_load = 1'b0;
        step(1);
        chk("R7 load ignored in parallel", 7'd33);
        le = 1'b1;
        par_code = 7'd77;
        step(1);
        chk("R8 parallel takes over", 7'd77);
        le = 1'b0;
        step(1);
        ps_serial = 1'b1;
        step(3);
        chk("R8 kept after switch to serial", 7'd77);
        ser_word = 7'd12;
        ser_load = 1'b1;
        step(1);
        ser_load = 1'b0;
        chk("R1 serial takes over", 7'd12);
    endtask

    task automatic t_pwrup_direct;
        power_up(1'b0, 1'b1, 7'd20);
        step(1);
        par_code = 7'd90;
        ser_word = 7'd3;
        ser_load = 1'b1;
        step(1);
        ser_load = 1'b0;
        step(398);
        chk("R6 still full scale at edge 400", 7'd127);
        step(1);
        chk("R6 pins adopted at edge 401", 7'd90);
        par_code = 7'd3;
        step(1);
        chk("R6 R4 direct after delay", 7'd3);
    endtask

    task automatic t_async_reset;
        step(1);
        rst_n = 1'b0;
        #1;
        chk("R9 async reset", 7'd127);
        step(2);
        ps_serial = 1'b0;
        le = 1'b0;
        par_code = 7'd8;
        rst_n = 1'b1;
        step(5);
        chk("R9 R5 rerun latched start", 7'd127);
    endtask

    initial begin
        t_pwrup_latched();
        t_direct_follow();
        t_pwrup_serial();
        t_mode_switch();
        t_pwrup_direct();
        t_async_reset();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule